// File: doc/BRIEF.md
# Phase-Pair Output Steering and Gating

This block sits between a three-phase PWM timing unit and the six gate-drive outputs. It receives the timing unit's high-side and low-side signals for phases A, B and C. A 9-bit control word decides, per phase, whether the high and low signals trade places. The swap serves commutation of electronically commutated and brushless DC motors. The same word can also force any single output to its OFF level (logic 0).

Software writes the control word through a simple bus port into a holding register. A read of that port returns the holding register. The steering logic does not use the holding register directly. It uses an active copy, and the holding register is transferred into the active copy only at update points. Every PWM sync pulse is an update point. When double update mode is selected, the cycle-midpoint pulse is one as well. As a result, a change takes effect on a clean cycle or half-cycle boundary.

The six-bit vectors `tu_in` and `pwm_out` share one pin order, counting from bit 0 upward: CL, CH, BL, BH, AL, AH.

Top module: `pwm_out_steer`

## Requirements
- R1: After reset, both the holding register and the active copy are zero. `rd_data` reads 0, and every `pwm_out` bit equals the matching `tu_in` bit.
- R2: A cycle with `wr_en` high loads `wr_data[8:0]` into the holding register at that clock edge. `rd_data` returns the holding register in bits 8..0, and its bits above 8 read as zero.
- R3: A `sync_pulse` at a clock edge copies the holding register into the active copy. The value copied is the one held before that edge, so a write in the same cycle lands only in the holding register.
- R4: At a clock edge, `mid_pulse` copies the holding register into the active copy only when `dbl_mode` is 1. When `dbl_mode` is 0, `mid_pulse` has no effect.
- R5: When no update point occurs, a write changes only the holding register. `pwm_out` keeps following the previous active copy.
- R6: Active bit 8 swaps the A pair, bit 7 swaps the B pair and bit 6 swaps the C pair. With a pair swapped, its high-side pin carries the timing unit's low-side signal and its low-side pin carries the high-side signal.
- R7: Active bits 0..5 disable the outputs CL, CH, BL, BH, AL and AH, in that order. A disabled output is 0 whatever its input.
- R8: Disabling applies to the pin after the swap. A disable bit silences its own pin even when that pin carries the partner's signal.
- R9: A pair whose swap bit is clear passes its input signals straight to its own pins, subject only to R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Write data; only bits 8..0 are kept |
| rd_data | output | DATA_W | Holding register, zero-extended |
| sync_pulse | input | 1 | PWM cycle-start pulse (update point) |
| mid_pulse | input | 1 | PWM cycle-midpoint pulse |
| dbl_mode | input | 1 | 1 selects double update mode |
| tu_in | input | 6 | Timing-unit signals {AH,AL,BH,BL,CH,CL} |
| pwm_out | output | 6 | Steered and gated outputs, same order |

## Verification
The checker's assertions are evaluated at every clock edge. They check that the active copy changes only at a valid update point and then takes the pre-edge holding value. They also check that the midpoint pulse is ignored in single update mode, that writes read back zero-extended, that disabled pins stay low, and that a clear word passes the inputs through. The bench's scenarios cover what a property cannot state in general. These are the exact pin routing of each swap bit, the disable bit winning over a swapped signal, and a write that coincides with a sync pulse. A cycle-level reference model compares `rd_data` and `pwm_out` on every cycle across directed and random traffic.

// File: rtl/pwm_out_steer.sv
module pwm_out_steer #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              sync_pulse,
  input  logic              mid_pulse,
  input  logic              dbl_mode,
  input  logic [5:0]        tu_in,
  output logic [5:0]        pwm_out
);
  localparam int CW    = 9;
  localparam int NPAIR = 3;
  localparam int XO0   = 2 * NPAIR;

  logic [CW-1:0] hold;
  logic [CW-1:0] act;
  logic          upd;

  assign upd = sync_pulse | (mid_pulse & dbl_mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold <= '0;
      act  <= '0;
    end else begin
      if (upd)   act  <= hold;
      if (wr_en) hold <= wr_data[CW-1:0];
    end
  end

  assign rd_data = {{(DATA_W-CW){1'b0}}, hold};

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    logic swp;
    assign swp = act[XO0+p];
    assign pwm_out[2*p+1] = (swp ? tu_in[2*p]   : tu_in[2*p+1]) & ~act[2*p+1];
    assign pwm_out[2*p]   = (swp ? tu_in[2*p+1] : tu_in[2*p])   & ~act[2*p];
  end
endmodule

// File: rtl/pwm_out_steer_chk.sv
module pwm_out_steer_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              sync_pulse,
  input logic              mid_pulse,
  input logic              dbl_mode,
  input logic [5:0]        tu_in,
  input logic [5:0]        pwm_out,
  input logic [8:0]        hold,
  input logic [8:0]        act
);
  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (rd_data == '0)); // R1
  AST_WRITE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == {{(DATA_W-9){1'b0}}, $past(wr_data[8:0])}); // R2
  AST_READ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data)); // R2
  AST_SYNC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |=> act == $past(hold)); // R3
  AST_MID_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (mid_pulse && !dbl_mode && !sync_pulse) |=> $stable(act)); // R4
  AST_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_pulse && !(mid_pulse && dbl_mode)) |=> $stable(act)); // R5
  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_out & act[5:0]) == 6'b0); // R7
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (act == 9'b0) |-> (pwm_out == tu_in)); // R9
endmodule

bind pwm_out_steer pwm_out_steer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .sync_pulse(sync_pulse), .mid_pulse(mid_pulse), .dbl_mode(dbl_mode),
  .tu_in(tu_in), .pwm_out(pwm_out), .hold(hold), .act(act)
);

// File: tb/pwm_out_steer_bench.sv
module pwm_out_steer_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        sync_pulse = 0, mid_pulse = 0, dbl_mode = 0;
  logic [5:0]  tu_in = '0;
  logic [5:0]  pwm_out;

  int checks = 0, failures = 0;
  bit done = 0;
  string cur_req = "R1";

  logic [8:0] m_hold = '0, m_act = '0;

  always #10 clk = ~clk;

  pwm_out_steer u_pwm_out_steer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .sync_pulse(sync_pulse), .mid_pulse(mid_pulse), .dbl_mode(dbl_mode),
    .tu_in(tu_in), .pwm_out(pwm_out)
  );

  // pin order: 0 CL, 1 CH, 2 BL, 3 BH, 4 AL, 5 AH
  function automatic logic [5:0] ref_out(input logic [8:0] w, input logic [5:0] t);
    logic [5:0] r;
    for (int pin = 0; pin < 6; pin++) begin
      int mate = (pin % 2 == 0) ? pin + 1 : pin - 1;
      logic v = w[6 + pin / 2] ? t[mate] : t[pin];
      r[pin] = w[pin] ? 1'b0 : v;
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hold <= '0;
      m_act  <= '0;
    end else begin
      if (sync_pulse || (mid_pulse && dbl_mode)) m_act <= m_hold;
      if (wr_en) m_hold <= wr_data[8:0];
    end
  end

  task automatic chk(input string r, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", r, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({cur_req, " rd_data"}, rd_data, {7'b0, m_hold});
      chk({cur_req, " pwm_out"}, {10'b0, pwm_out}, {10'b0, ref_out(m_act, tu_in)});
    end
  end

  task automatic adv();
    @(posedge clk);
    @(negedge clk);
    #2;
    wr_en = 0; sync_pulse = 0; mid_pulse = 0;
  endtask

  task automatic wr(input logic [15:0] d);
    wr_en = 1; wr_data = d; adv();
  endtask

  task automatic sync1();
    sync_pulse = 1; adv();
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    rst_n = 1;
    tu_in = 6'b011001;
    adv();
    cur_req = "R1";
    chk("R1", rd_data, 16'h0000);
    chk("R1", {10'b0, pwm_out}, {10'b0, 6'b011001});

    cur_req = "R2";
    wr(16'hFFFF);
    chk("R2", rd_data, 16'h01FF);
    cur_req = "R5";
    tu_in = 6'b110011; adv();
    chk("R5", {10'b0, pwm_out}, {10'b0, 6'b110011});
    cur_req = "R7";
    sync1();
    chk("R7", {10'b0, pwm_out}, 16'h0000);

    cur_req = "R6";
    wr(16'h01C0); sync1();
    tu_in = 6'b101010; adv();
    chk("R6", {10'b0, pwm_out}, {10'b0, 6'b010101});
    wr(16'h0080); sync1();
    tu_in = 6'b001000; adv();
    chk("R6", {10'b0, pwm_out}, {10'b0, 6'b000100});

    cur_req = "R8";
    wr(16'h009B); sync1();
    tu_in = 6'b101000; adv();
    chk("R8", {10'b0, pwm_out}, {10'b0, 6'b100100});
    wr(16'h0110); sync1();
    tu_in = 6'b100000; adv();
    chk("R8", {10'b0, pwm_out}, 16'h0000);

    cur_req = "R9";
    wr(16'h0000); sync1();
    tu_in = 6'b010110; adv();
    chk("R9", {10'b0, pwm_out}, {10'b0, 6'b010110});

    cur_req = "R4";
    wr(16'h003F);
    dbl_mode = 0; mid_pulse = 1; adv();
    chk("R4", {10'b0, pwm_out}, {10'b0, 6'b010110});
    dbl_mode = 1; mid_pulse = 1; adv();
    chk("R4", {10'b0, pwm_out}, 16'h0000);
    dbl_mode = 0;

    cur_req = "R3";
    wr(16'h0000); sync1();
    wr_en = 1; wr_data = 16'h003F; sync_pulse = 1; adv();
    chk("R3", {10'b0, pwm_out}, {10'b0, 6'b010110});
    chk("R3", rd_data, 16'h003F);
    sync1();
    chk("R3", {10'b0, pwm_out}, 16'h0000);

    cur_req = "R6 random";
    for (int i = 0; i < 400; i++) begin
      tu_in      = 6'($urandom);
      wr_en      = ($urandom % 4) == 0;
      wr_data    = 16'($urandom);
      sync_pulse = ($urandom % 5) == 0;
      mid_pulse  = ($urandom % 5) == 0;
      dbl_mode   = ($urandom % 2) == 0;
      @(posedge clk); @(negedge clk); #2;
    end
    wr_en = 0; sync_pulse = 0; mid_pulse = 0;
    adv();
    finish_run();
  end
endmodule